// File: doc/BRIEF.md
# Phase Accumulator Core with Double-Buffered Tuning

This block generates a running phase for a numerically controlled oscillator. A 32-bit accumulator adds an active tuning word on every clock. The upper 14 bits of the accumulator, plus an active 14-bit offset, form a registered phase word. A downstream stage turns that word into an amplitude. The output frequency is tuning × fclk / 2^32. A tuning word of 2^31 or more aliases to fclk × (1 − tuning/2^32). The offset moves the phase by 360 × offset / 2^14 degrees.

Software writes a tuning word, an offset word and two clear controls into shadow registers. These values reach the active registers only on a single-cycle update strobe, so one strobe retunes the oscillator in a single step.

One clear control holds the accumulator at zero for as long as it is active. The other zeroes it once after each update strobe. At reset the active hold-clear is asserted and its shadow copy is not. The phase therefore stays at zero until the first strobe.

Top module: `nco_phase_core`

## Requirements
- R1: After reset, phase_o is 0. It stays 0 until the first io_update_i, even if a tuning word is written into the shadow registers, because the active hold-clear resets to 1 and its shadow copy resets to 0.
- R2: A write with wr_en_i high stores wr_data_i in a shadow register only. The selected register is: 0 for control, 1 for the tuning word (all 32 bits), 2 for the offset (bits 13:0). Shadow contents reach the active registers only at a rising clock edge where io_update_i is high.
- R3: At each clock edge the accumulator becomes its previous value plus the active tuning word, modulo 2^32, unless a clear applies.
- R4: A tuning word at or above 2^31 wraps modulo 2^32. For example, 0x80000000 moves the phase by 0x2000 on every cycle, and 0xFFFC0000 lowers it by 1 on every cycle.
- R5: A tuning word of 0 holds the accumulator at its current value. It does not clear the accumulator.
- R6: phase_o equals (accumulator[31:18] + active offset) modulo 2^14. An offset of 0 leaves the phase running from its current value. It does not force zero phase.
- R7: While control bit 8 (hold-clear) is active, the accumulator is forced to 0 at every edge.
- R8: When control bit 13 (auto-clear) is active, the accumulator is zeroed once, at the edge after each update strobe. It then resumes accumulating.
- R9: phase_o is registered. It reflects the accumulator and offset as they stood one clock earlier.
- R10: A write to address 3 changes no register. phase_o is unaffected, even after a following update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Shadow register write enable |
| wr_addr_i | input | 2 | Shadow register select |
| wr_data_i | input | 32 | Write data |
| io_update_i | input | 1 | Single-cycle strobe that copies shadow values to active registers |
| phase_o | output | 14 | Registered phase word |

## Verification
The update strobe loads the active registers at its own edge. The accumulator uses the new tuning word from the next edge. The changed accumulator appears on phase_o one edge after that, so a retune shows up on the phase two edges after the strobe. An auto-clear zeroes the accumulator at the edge after the strobe, and phase_o shows that zero at the edge after it. The bench keeps a behavioural model that advances on each rising edge using these same latencies. It compares phase_o to the model at each falling edge, and it samples its directed checks at falling edges counted from the strobe.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_FTW  = 2'd1,
    SEL_POW  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_AUTO_BIT = 13;
  localparam int unsigned CTRL_HOLD_BIT = 8;

  typedef struct packed {
    logic auto_clr;
    logic hold_clr;
  } clr_ctl_t;
endpackage

// File: rtl/nco_regfile.sv
module nco_regfile
  import nco_pkg::*;
#(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned PHASE_W = 14,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               io_update_i,
  output logic [ACC_W-1:0]   ftw_o,
  output logic [PHASE_W-1:0] pow_o,
  output clr_ctl_t           clr_o,
  output logic               upd_q_o
);
  logic [ACC_W-1:0]   ftw_sh, ftw_q;
  logic [PHASE_W-1:0] pow_sh, pow_q;
  clr_ctl_t           clr_sh, clr_q;
  reg_sel_e           sel;

  assign sel = reg_sel_e'(wr_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftw_sh <= '0;
      pow_sh <= '0;
      clr_sh <= '0;
    end else if (wr_en_i) begin
      unique case (sel)
        SEL_CTRL: begin
          clr_sh.auto_clr <= wr_data_i[CTRL_AUTO_BIT];
          clr_sh.hold_clr <= wr_data_i[CTRL_HOLD_BIT];
        end
        SEL_FTW:  ftw_sh <= wr_data_i[ACC_W-1:0];
        SEL_POW:  pow_sh <= wr_data_i[PHASE_W-1:0];
        default:  ;
      endcase
    end
  end

  // active set: hold-clear powers up asserted, shadow does not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftw_q   <= '0;
      pow_q   <= '0;
      clr_q   <= '{auto_clr: 1'b0, hold_clr: 1'b1};
      upd_q_o <= 1'b0;
    end else begin
      upd_q_o <= io_update_i;
      if (io_update_i) begin
        ftw_q <= ftw_sh;
        pow_q <= pow_sh;
        clr_q <= clr_sh;
      end
    end
  end

  assign ftw_o = ftw_q;
  assign pow_o = pow_q;
  assign clr_o = clr_q;
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned PHASE_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ACC_W-1:0]   ftw_i,
  input  logic               hold_clr_i,
  input  logic               pulse_clr_i,
  output logic [PHASE_W-1:0] acc_hi_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    if (hold_clr_i || pulse_clr_i) acc_d = '0;
    else                           acc_d = acc_q + ftw_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_hi_o = acc_q[ACC_W-1 -: PHASE_W];
endmodule

// File: rtl/nco_phase_out.sv
module nco_phase_out #(
  parameter int unsigned PHASE_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] acc_hi_i,
  input  logic [PHASE_W-1:0] pow_i,
  output logic [PHASE_W-1:0] phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= '0;
    else         phase_o <= acc_hi_i + pow_i;
  end
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
  import nco_pkg::*;
#(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned PHASE_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [ACC_W-1:0]   wr_data_i,
  input  logic               io_update_i,
  output logic [PHASE_W-1:0] phase_o
);
  localparam int unsigned DATA_W = ACC_W;

  logic [ACC_W-1:0]   ftw_act;
  logic [PHASE_W-1:0] pow_act;
  logic [PHASE_W-1:0] acc_hi;
  clr_ctl_t           clr_act;
  logic               upd_q;
  logic               pulse_clr;

  nco_regfile #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .io_update_i (io_update_i),
    .ftw_o       (ftw_act),
    .pow_o       (pow_act),
    .clr_o       (clr_act),
    .upd_q_o     (upd_q)
  );

  // auto-clear fires once, on the edge after the strobe
  assign pulse_clr = upd_q & clr_act.auto_clr;

  nco_accum #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ftw_i       (ftw_act),
    .hold_clr_i  (clr_act.hold_clr),
    .pulse_clr_i (pulse_clr),
    .acc_hi_o    (acc_hi)
  );

  nco_phase_out #(.PHASE_W(PHASE_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_hi_i (acc_hi),
    .pow_i    (pow_act),
    .phase_o  (phase_o)
  );
endmodule

// File: rtl/nco_phase_core_chk.sv
module nco_phase_core_chk #(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned PHASE_W = 14
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               io_update_i,
  input logic [ACC_W-1:0]   ftw_q,
  input logic [PHASE_W-1:0] pow_q,
  input logic               hold_q,
  input logic               auto_q,
  input logic               upd_q,
  input logic [ACC_W-1:0]   acc_q,
  input logic [PHASE_W-1:0] phase_o
);
  AST_SHADOW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_update_i |=> ($stable(ftw_q) && $stable(pow_q) && $stable(hold_q))); // R2

  AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_q && !(upd_q && auto_q)) |=> (acc_q == $past(acc_q) + $past(ftw_q))); // R3

  AST_HOLD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |=> (acc_q == '0)); // R7

  AST_AUTO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_q && auto_q) |=> (acc_q == '0)); // R8

  AST_PHASE_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (phase_o == PHASE_W'($past(acc_q[ACC_W-1 -: PHASE_W]) + $past(pow_q)))); // R9
endmodule

bind nco_phase_core nco_phase_core_chk #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .io_update_i (io_update_i),
  .ftw_q       (ftw_act),
  .pow_q       (pow_act),
  .hold_q      (clr_act.hold_clr),
  .auto_q      (clr_act.auto_clr),
  .upd_q       (upd_q),
  .acc_q       (u_acc.acc_q),
  .phase_o     (phase_o)
);

// File: tb/nco_phase_core_test.sv
module nco_phase_core_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = 2'd0;
  logic [31:0] wr_data_i = '0;
  logic        io_update_i = 1'b0;
  logic [13:0] phase_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  nco_phase_core uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .io_update_i(io_update_i), .phase_o(phase_o)
  );

  // behavioural reference model
  int unsigned m_acc, m_ftw, s_ftw, n_acc;
  int unsigned m_pow, s_pow, m_phase, n_phase;
  bit m_hold, m_auto, s_hold, s_auto, m_updd;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_acc = 0; m_ftw = 0; s_ftw = 0; m_pow = 0; s_pow = 0; m_phase = 0;
      m_hold = 1; m_auto = 0; s_hold = 0; s_auto = 0; m_updd = 0;
    end else begin
      n_phase = ((m_acc >> 18) + m_pow) % 16384;
      n_acc   = (m_hold || (m_updd && m_auto)) ? 0 : m_acc + m_ftw;
      if (io_update_i) begin
        m_ftw = s_ftw; m_pow = s_pow; m_hold = s_hold; m_auto = s_auto;
      end
      m_updd = io_update_i;
      if (wr_en_i) begin
        case (wr_addr_i)
          2'd0: begin s_auto = wr_data_i[13]; s_hold = wr_data_i[8]; end
          2'd1: s_ftw = wr_data_i;
          2'd2: s_pow = wr_data_i & 32'h3fff;
          default: ;
        endcase
      end
      m_acc = n_acc;
      m_phase = n_phase;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk_i)
    if (rst_ni && !done) chk(phase_o == 14'(m_phase), "R3/R9 model", int'(phase_o), int'(m_phase));

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse();
    io_update_i = 1'b1;
    @(negedge clk_i);
    io_update_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic delta_chk(input int exp, input string req);
    logic [13:0] p0;
    p0 = phase_o;
    @(negedge clk_i);
    chk(14'(phase_o - p0) == 14'(exp), req, int'(14'(phase_o - p0)), exp);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    done = 1'b1;
    summary();
  end

  initial begin
    logic [13:0] base;
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    chk(phase_o == 0, "R1 reset", int'(phase_o), 0);
    wr(2'd1, 32'h0004_0000);
    idle(5);
    chk(phase_o == 0, "R1 R2 shadow only", int'(phase_o), 0);

    // release clear: ctrl=0, update
    wr(2'd0, 32'h0);
    pulse();
    idle(9);
    chk(phase_o == 14'd8, "R3 step count", int'(phase_o), 8);
    delta_chk(1, "R3 delta");

    wr(2'd1, 32'h8000_0000);
    pulse();
    idle(3);
    delta_chk(14'h2000, "R4 half-scale");
    wr(2'd1, 32'hFFFC_0000);
    pulse();
    idle(3);
    delta_chk(14'h3fff, "R4 negative step");

    wr(2'd1, 32'h0);
    pulse();
    idle(3);
    base = phase_o;
    idle(4);
    chk(phase_o == base, "R5 zero ftw holds", int'(phase_o), int'(base));

    wr(2'd2, 32'h100);
    pulse();
    idle(2);
    chk(phase_o == 14'(base + 14'h100), "R6 offset add", int'(phase_o), int'(14'(base + 14'h100)));
    wr(2'd2, 32'h0);
    pulse();
    idle(2);
    chk(phase_o == base, "R6 zero offset keeps phase", int'(phase_o), int'(base));

    wr(2'd3, 32'hFFFF_FFFF);
    pulse();
    idle(3);
    chk(phase_o == base, "R10 unused address", int'(phase_o), int'(base));

    // hold-clear
    wr(2'd1, 32'h0004_0000);
    wr(2'd0, 32'h0000_0100);
    pulse();
    idle(4);
    chk(phase_o == 0, "R7 hold clear", int'(phase_o), 0);
    idle(4);
    chk(phase_o == 0, "R7 hold persists", int'(phase_o), 0);

    // auto-clear
    wr(2'd0, 32'h0000_2000);
    pulse();
    idle(2);
    chk(phase_o == 0, "R8 auto clear", int'(phase_o), 0);
    idle(1);
    chk(phase_o == 1, "R8 resume", int'(phase_o), 1);
    idle(10);
    chk(phase_o == 11, "R8 one-shot", int'(phase_o), 11);
    pulse();
    idle(2);
    chk(phase_o == 0, "R8 per update", int'(phase_o), 0);

    // random tuning words, model compared every cycle
    wr(2'd0, 32'h0);
    for (int i = 0; i < 200; i++) begin
      logic [31:0] f;
      f = $urandom;
      if (i % 3 == 0) f[31] = 1'b1;
      if (i == 5) f = 32'h8000_0000;
      if (i == 6) f = 32'hFFFF_FFFF;
      wr(2'd1, f);
      if (i % 7 == 0) wr(2'd2, $urandom);
      pulse();
      idle(4);
    end

    done = 1'b1;
    summary();
  end
endmodule